// File: doc/BRIEF.md
# SPI Opcode Sequencer Engine

This block is the control engine of a SPI controller. Software loads a word of eight 8-bit opcodes, and the engine steps through them one opcode per clock. The upper nibble of each opcode picks the operation and the lower nibble is its argument. The engine drives chip select, asks a payload builder for the first (N1) and second (N2) segments of a frame, branches on the result of a receive-data compare, and runs two bounded loops. It keeps a sequence index, a sequencer state and a shifter state.

A run begins when software writes the transmit data register. A run stops in one of three ways. A stop opcode or running off the end of the slot list returns the engine to idle. An error halts the engine with the index held. A missing resource (empty transmit data, full receive data, or a receive compare with no data) parks the shifter in a wait state. A later transmit-data write, or a receive-data read while waiting, resumes the run at the held index. A two-step write to a reset-control field puts the whole engine back to its reset state.

Top module: `spi_op_sequencer`

## Requirements
- R1: Slot i occupies bits [63-8i -: 8] of `opWord`, and its upper nibble selects the operation. A `tdrWrite` while the sequencer is idle (`seqState`=0) starts a run (`seqState`=1) at index 0. The opcode at the current index executes on the following clock, and each clock executes one opcode.
- R2: Opcode 0x1 (select) behaves by argument. Argument 1 drives `csN` low, sets the shifter to START (1) and advances the index. Argument 0 drives `csN` high, sets the shifter to DONE (5) and advances. Any other argument sets the shifter to IDLE (0) and halts (`seqState`=2) with the index unchanged.
- R3: An error sets `seqError` and halts with the index unchanged. This happens for a 0x3 (shift N1) while the shifter is IDLE or DONE, and for a 0x4 (shift N2) with no N1 done since the last select with argument 1. `seqError` clears when the next run starts.
- R4: A 0x3 raises `shiftN1Req` for that cycle and a 0x4 raises `shiftN2Req`, each with `shiftArg` equal to the low nibble. `shiftCombine` is 1 with an N1 request exactly when the next slot's upper nibble is 4. A completed N1 sets the shifter to 2 and a completed N2 sets it to 3, and both advance the index.
- R5: When a combined N1 completes with `n2Reload` set, the engine sets `tdrUnderrun`, advances the index, sets the shifter to 3 and halts.
- R6: If `shiftStop` is high during a shift request, the shifter goes to WAIT (4) and the engine halts with the index held. `tdrWrite` sets `tdrFull`, clears `tdrUnderrun` and resumes a halted run at its index. `tdrTaken` clears `tdrFull`. `rdrRead` clears `rdrFull`, and it resumes the run only while the shifter is in WAIT; it does not start a run from idle.
- R7: Opcode 0x6 compares the receive data. With `rdrFull` low, the shifter goes to WAIT and the engine halts. Otherwise it clears `rdrFull`, advances on `rdrMatch` and jumps to the low-nibble target on a mismatch.
- R8: Opcodes 0xE and 0xF are loop branches using counter 1 (compare `loopCmp1`) and counter 2 (compare `loopCmp2`). While the counter differs from its compare value, the branch jumps to the low-nibble target and increments the counter. Otherwise it advances. The loop body therefore repeats exactly the compare value times.
- R9: Opcode 0x0, or an index reaching 8, returns the engine to idle with index 0 and both loop counters cleared. The 0x0 opcode also sets the shifter to IDLE. A jump target of 8 or more ends the run the same way.
- R10: Writing 0x5 and then 0xA to `rstCtlVal` with `rstCtlWrite` resets the engine: `csN` high, all flags clear, idle, index 0. Any other value written between the two cancels the sequence.
- R11: Opcode 0x2 and all unassigned upper nibbles only advance the index.
- R12: After `rstN` the engine is idle with index 0, the shifter IDLE, `csN` high and all flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opWord | input | 64 | Eight opcode slots, slot 0 in the top byte |
| loopCmp1 | input | 4 | Compare value for loop counter 1 |
| loopCmp2 | input | 4 | Compare value for loop counter 2 |
| n2Reload | input | 1 | N2 counter-reload setting |
| rdrMatch | input | 1 | Receive-data compare result from the receive block |
| shiftStop | input | 1 | Payload builder cannot complete the requested shift |
| tdrTaken | input | 1 | Payload builder consumed the transmit data |
| rdrLoaded | input | 1 | Receive block loaded new receive data |
| tdrWrite | input | 1 | Software wrote the transmit data register |
| rdrRead | input | 1 | Software read the receive data register |
| rstCtlWrite | input | 1 | Write strobe for the reset-control field |
| rstCtlVal | input | 4 | Value written to the reset-control field |
| csN | output | 1 | Chip select, active low |
| shiftN1Req | output | 1 | N1 segment request |
| shiftN2Req | output | 1 | N2 segment request |
| shiftArg | output | 4 | Low nibble of the current opcode |
| shiftCombine | output | 1 | N1 is held and sent with the following N2 |
| seqIndex | output | 4 | Current sequence index (0 to 8) |
| seqState | output | 2 | 0 idle, 1 running, 2 halted |
| shifterState | output | 3 | 0 IDLE, 1 START, 2 N1, 3 N2, 4 WAIT, 5 DONE |
| tdrFull | output | 1 | Transmit data present |
| rdrFull | output | 1 | Receive data present |
| tdrUnderrun | output | 1 | N1 held for a reloaded N2 |
| seqError | output | 1 | Sequencer error |

## Verification
The bench builds the block with its default parameters: eight slots, 8-bit opcodes and 4-bit loop compares. With a 4-bit compare, the loop tests cover the full compare range 0 to 15 for both counters, including nested loops with random compare pairs. Eight slots keep a straight-line program short enough that the bench can walk the index to its end value and check the return to idle. Directed programs reach each halt and resume path, the combined N1/N2 frame with and without counter reload, and both branch outcomes.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HALT = 2'd2
  } seqState_e;

  typedef enum logic [2:0] {
    SH_IDLE  = 3'd0,
    SH_START = 3'd1,
    SH_N1    = 3'd2,
    SH_N2    = 3'd3,
    SH_WAIT  = 3'd4,
    SH_DONE  = 3'd5
  } shState_e;

  localparam logic [3:0] OP_STOP   = 4'h0;
  localparam logic [3:0] OP_SEL    = 4'h1;
  localparam logic [3:0] OP_XFER   = 4'h2;
  localparam logic [3:0] OP_N1     = 4'h3;
  localparam logic [3:0] OP_N2     = 4'h4;
  localparam logic [3:0] OP_BRANCH = 4'h6;
  localparam logic [3:0] OP_LOOP1  = 4'hE;
  localparam logic [3:0] OP_LOOP2  = 4'hF;

  localparam logic [3:0] RST_KEY1 = 4'h5;
  localparam logic [3:0] RST_KEY2 = 4'hA;

  // Strobes from the control FSM into the flag datapath
  typedef struct packed {
    logic setErr;
    logic clrErr;
    logic setUnderrun;
    logic clrRdrFull;
    logic csLow;
    logic csHigh;
  } flagStrobes_t;

endpackage

// File: rtl/sqc_flags.sv
module sqc_flags
  import sqc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  flagStrobes_t strb,
  input  logic         tdrWrite,
  input  logic         tdrTaken,
  input  logic         rdrLoaded,
  input  logic         rdrRead,
  input  logic         rstCtlWrite,
  input  logic [3:0]   rstCtlVal,
  output logic         softRst,
  output logic         csN,
  output logic         tdrFull,
  output logic         rdrFull,
  output logic         tdrUnderrun,
  output logic         seqError
);

  logic armedQ;

  // The second key only counts right after the first key
  assign softRst = rstCtlWrite && (rstCtlVal == RST_KEY2) && armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ      <= 1'b0;
      csN         <= 1'b1;
      tdrFull     <= 1'b0;
      rdrFull     <= 1'b0;
      tdrUnderrun <= 1'b0;
      seqError    <= 1'b0;
    end else if (softRst) begin
      armedQ      <= 1'b0;
      csN         <= 1'b1;
      tdrFull     <= 1'b0;
      rdrFull     <= 1'b0;
      tdrUnderrun <= 1'b0;
      seqError    <= 1'b0;
    end else begin
      if (rstCtlWrite) armedQ <= (rstCtlVal == RST_KEY1);

      if (tdrWrite)      tdrFull <= 1'b1;
      else if (tdrTaken) tdrFull <= 1'b0;

      if (strb.setUnderrun) tdrUnderrun <= 1'b1;
      else if (tdrWrite)    tdrUnderrun <= 1'b0;

      if (rdrLoaded)                       rdrFull <= 1'b1;
      else if (rdrRead || strb.clrRdrFull) rdrFull <= 1'b0;

      if (strb.setErr)      seqError <= 1'b1;
      else if (strb.clrErr) seqError <= 1'b0;

      if (strb.csLow)       csN <= 1'b0;
      else if (strb.csHigh) csN <= 1'b1;
    end
  end

  // R10: the key sequence leaves every flag clear and chip select high
  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (csN && !tdrFull && !rdrFull && !tdrUnderrun && !seqError));

endmodule

// File: rtl/sqc_ctrl.sv
module sqc_ctrl
  import sqc_pkg::*;
#(
  parameter int NUM_OPS = 8,
  parameter int OP_W    = 8,
  parameter int CNT_W   = 4,
  localparam int SLOT_W = $clog2(NUM_OPS),
  localparam int IDX_W  = SLOT_W + 1,
  localparam int ARG_W  = OP_W / 2
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  softRst,
  input  logic [NUM_OPS*OP_W-1:0] opWord,
  input  logic [CNT_W-1:0]      loopCmp1,
  input  logic [CNT_W-1:0]      loopCmp2,
  input  logic                  n2Reload,
  input  logic                  rdrMatch,
  input  logic                  shiftStop,
  input  logic                  tdrWrite,
  input  logic                  rdrRead,
  input  logic                  rdrFull,
  output flagStrobes_t          strb,
  output logic                  shiftN1Req,
  output logic                  shiftN2Req,
  output logic [ARG_W-1:0]      shiftArg,
  output logic                  shiftCombine,
  output logic [IDX_W-1:0]      seqIndex,
  output logic [1:0]            seqStateOut,
  output logic [2:0]            shifterStateOut
);

  logic [OP_W-1:0] opSlot [NUM_OPS];

  // Slot 0 is the most significant byte of the opcode word
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_slot
    assign opSlot[g] = opWord[OP_W*(NUM_OPS-g)-1 -: OP_W];
  end

  logic [IDX_W-1:0] idxQ, idxD, nxtIdx, jumpTarget;
  seqState_e        seqQ, seqD;
  shState_e         shQ, shD;
  logic             n1DoneQ, n1DoneD;
  logic [CNT_W-1:0] cntQ [2];
  logic [CNT_W-1:0] cmpVal [2];
  logic [1:0]       cntInc;
  logic             cntClr;
  logic             idxValid, nextIsN2, startReq, loopSel;
  logic [OP_W-1:0]  curOp, nextOp;
  logic [OP_W-ARG_W-1:0] opCode;
  logic [ARG_W-1:0] opArg;

  assign cmpVal[0] = loopCmp1;
  assign cmpVal[1] = loopCmp2;

  assign idxValid   = idxQ < IDX_W'(NUM_OPS);
  assign curOp      = idxValid ? opSlot[idxQ[SLOT_W-1:0]] : '0;
  assign nxtIdx     = idxQ + IDX_W'(1);
  assign nextOp     = (nxtIdx < IDX_W'(NUM_OPS)) ? opSlot[nxtIdx[SLOT_W-1:0]] : '0;
  assign nextIsN2   = (nextOp[OP_W-1:ARG_W] == OP_N2);
  assign opCode     = curOp[OP_W-1:ARG_W];
  assign opArg      = curOp[ARG_W-1:0];
  assign loopSel    = opCode[0];
  assign jumpTarget = (int'(opArg) >= NUM_OPS) ? IDX_W'(NUM_OPS) : IDX_W'(opArg);
  assign startReq   = tdrWrite || (rdrRead && shQ == SH_WAIT);
  assign shiftArg   = opArg;

  always_comb begin
    idxD = idxQ;  seqD = seqQ;  shD = shQ;  n1DoneD = n1DoneQ;
    cntInc = '0;  cntClr = 1'b0;  strb = '0;
    shiftN1Req = 1'b0;  shiftN2Req = 1'b0;  shiftCombine = 1'b0;
    if (seqQ != SEQ_RUN) begin
      if (startReq) begin
        seqD = SEQ_RUN;
        strb.clrErr = 1'b1;
        if (seqQ == SEQ_IDLE) idxD = '0;
      end
    end else if (!idxValid) begin
      seqD = SEQ_IDLE;  idxD = '0;  cntClr = 1'b1;
    end else begin
      case (opCode)
        OP_STOP: begin
          seqD = SEQ_IDLE;  idxD = '0;  cntClr = 1'b1;  shD = SH_IDLE;
        end
        OP_SEL: begin
          if (opArg == ARG_W'(1)) begin
            strb.csLow = 1'b1;  shD = SH_START;  n1DoneD = 1'b0;  idxD = nxtIdx;
          end else if (opArg == '0) begin
            strb.csHigh = 1'b1;  shD = SH_DONE;  idxD = nxtIdx;
          end else begin
            shD = SH_IDLE;  seqD = SEQ_HALT;
          end
        end
        OP_N1: begin
          if (shQ == SH_IDLE || shQ == SH_DONE) begin
            strb.setErr = 1'b1;  seqD = SEQ_HALT;
          end else begin
            shiftN1Req = 1'b1;  shiftCombine = nextIsN2;
            if (shiftStop) begin
              shD = SH_WAIT;  seqD = SEQ_HALT;
            end else begin
              n1DoneD = 1'b1;  idxD = nxtIdx;
              if (nextIsN2 && n2Reload) begin
                strb.setUnderrun = 1'b1;  shD = SH_N2;  seqD = SEQ_HALT;
              end else begin
                shD = SH_N1;
              end
            end
          end
        end
        OP_N2: begin
          if (!n1DoneQ) begin
            strb.setErr = 1'b1;  seqD = SEQ_HALT;
          end else begin
            shiftN2Req = 1'b1;
            if (shiftStop) begin
              shD = SH_WAIT;  seqD = SEQ_HALT;
            end else begin
              shD = SH_N2;  idxD = nxtIdx;
            end
          end
        end
        OP_BRANCH: begin
          if (!rdrFull) begin
            shD = SH_WAIT;  seqD = SEQ_HALT;
          end else begin
            strb.clrRdrFull = 1'b1;
            idxD = rdrMatch ? nxtIdx : jumpTarget;
          end
        end
        OP_LOOP1, OP_LOOP2: begin
          if (cntQ[loopSel] != cmpVal[loopSel]) begin
            idxD = jumpTarget;  cntInc[loopSel] = 1'b1;
          end else begin
            idxD = nxtIdx;
          end
        end
        OP_XFER: idxD = nxtIdx;
        default: idxD = nxtIdx;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;  seqQ <= SEQ_IDLE;  shQ <= SH_IDLE;  n1DoneQ <= 1'b0;
      for (int k = 0; k < 2; k++) cntQ[k] <= '0;
    end else if (softRst) begin
      idxQ <= '0;  seqQ <= SEQ_IDLE;  shQ <= SH_IDLE;  n1DoneQ <= 1'b0;
      for (int k = 0; k < 2; k++) cntQ[k] <= '0;
    end else begin
      idxQ <= idxD;  seqQ <= seqD;  shQ <= shD;  n1DoneQ <= n1DoneD;
      for (int k = 0; k < 2; k++) begin
        if (cntClr)         cntQ[k] <= '0;
        else if (cntInc[k]) cntQ[k] <= cntQ[k] + CNT_W'(1);
      end
    end
  end

  assign seqIndex        = idxQ;
  assign seqStateOut     = seqQ;
  assign shifterStateOut = shQ;

  // R9: index never passes the end position
  p_index_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= IDX_W'(NUM_OPS));
  // R9: an idle engine always sits at index 0
  p_idle_index_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seqQ == SEQ_IDLE) |-> (idxQ == '0));
  // R4: at most one segment request per cycle
  p_single_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftN1Req && shiftN2Req));
  // R4: a combine hint only accompanies an N1 request
  p_combine_n1_r4: assert property (@(posedge clk) disable iff (!rstN)
    shiftCombine |-> shiftN1Req);

endmodule

// File: rtl/spi_op_sequencer.sv
module spi_op_sequencer
  import sqc_pkg::*;
#(
  parameter int NUM_OPS = 8,
  parameter int OP_W    = 8,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_OPS) + 1,
  localparam int ARG_W  = OP_W / 2
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_OPS*OP_W-1:0] opWord,
  input  logic [CNT_W-1:0]        loopCmp1,
  input  logic [CNT_W-1:0]        loopCmp2,
  input  logic                    n2Reload,
  input  logic                    rdrMatch,
  input  logic                    shiftStop,
  input  logic                    tdrTaken,
  input  logic                    rdrLoaded,
  input  logic                    tdrWrite,
  input  logic                    rdrRead,
  input  logic                    rstCtlWrite,
  input  logic [3:0]              rstCtlVal,
  output logic                    csN,
  output logic                    shiftN1Req,
  output logic                    shiftN2Req,
  output logic [ARG_W-1:0]        shiftArg,
  output logic                    shiftCombine,
  output logic [IDX_W-1:0]        seqIndex,
  output logic [1:0]              seqState,
  output logic [2:0]              shifterState,
  output logic                    tdrFull,
  output logic                    rdrFull,
  output logic                    tdrUnderrun,
  output logic                    seqError
);

  flagStrobes_t strb;
  logic         softRst;

  sqc_ctrl #(.NUM_OPS(NUM_OPS), .OP_W(OP_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .opWord(opWord),
    .loopCmp1(loopCmp1), .loopCmp2(loopCmp2), .n2Reload(n2Reload),
    .rdrMatch(rdrMatch), .shiftStop(shiftStop), .tdrWrite(tdrWrite),
    .rdrRead(rdrRead), .rdrFull(rdrFull), .strb(strb),
    .shiftN1Req(shiftN1Req), .shiftN2Req(shiftN2Req), .shiftArg(shiftArg),
    .shiftCombine(shiftCombine), .seqIndex(seqIndex),
    .seqStateOut(seqState), .shifterStateOut(shifterState)
  );

  sqc_flags u_flags (
    .clk(clk), .rstN(rstN), .strb(strb), .tdrWrite(tdrWrite),
    .tdrTaken(tdrTaken), .rdrLoaded(rdrLoaded), .rdrRead(rdrRead),
    .rstCtlWrite(rstCtlWrite), .rstCtlVal(rstCtlVal), .softRst(softRst),
    .csN(csN), .tdrFull(tdrFull), .rdrFull(rdrFull),
    .tdrUnderrun(tdrUnderrun), .seqError(seqError)
  );

  // R2: chip select only falls together with the shifter entering START
  p_cs_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (shifterState == 3'(SH_START)));
  // R3: a freshly started run carries no error
  p_run_clears_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqState == 2'(SEQ_RUN)) |-> !seqError);
  // R5: underrun only appears as the engine halts
  p_underrun_halts_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tdrUnderrun) |-> (seqState == 2'(SEQ_HALT)));

endmodule

// File: tb/spi_op_sequencer_tb.sv
`timescale 1ns/1ps
module spi_op_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] opWord;
  logic [3:0]  loopCmp1, loopCmp2, rstCtlVal, shiftArg, seqIndex;
  logic        n2Reload, rdrMatch, shiftStop, tdrTaken, rdrLoaded;
  logic        tdrWrite, rdrRead, rstCtlWrite;
  logic        csN, shiftN1Req, shiftN2Req, shiftCombine;
  logic [1:0]  seqState;
  logic [2:0]  shifterState;
  logic        tdrFull, rdrFull, tdrUnderrun, seqError;

  int nChecks = 0;
  int nFail = 0;
  int n1Count = 0;
  int maxIdx = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_op_sequencer u_dut (
    .clk(clk), .rstN(rstN), .opWord(opWord), .loopCmp1(loopCmp1),
    .loopCmp2(loopCmp2), .n2Reload(n2Reload), .rdrMatch(rdrMatch),
    .shiftStop(shiftStop), .tdrTaken(tdrTaken), .rdrLoaded(rdrLoaded),
    .tdrWrite(tdrWrite), .rdrRead(rdrRead), .rstCtlWrite(rstCtlWrite),
    .rstCtlVal(rstCtlVal), .csN(csN), .shiftN1Req(shiftN1Req),
    .shiftN2Req(shiftN2Req), .shiftArg(shiftArg), .shiftCombine(shiftCombine),
    .seqIndex(seqIndex), .seqState(seqState), .shifterState(shifterState),
    .tdrFull(tdrFull), .rdrFull(rdrFull), .tdrUnderrun(tdrUnderrun),
    .seqError(seqError)
  );

  always @(negedge clk) if (shiftN1Req) n1Count++;

  function automatic logic [63:0] mk(input logic [7:0] a0 = 0, a1 = 0, a2 = 0,
      a3 = 0, a4 = 0, a5 = 0, a6 = 0, a7 = 0);
    return {a0, a1, a2, a3, a4, a5, a6, a7};
  endfunction

  // Expected N1 shifts for the nested loop program (R8)
  function automatic int expLoopShifts(input int c1, input int c2);
    return c1 + c2 + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulseTdr();
    @(negedge clk); tdrWrite = 1'b1;
    @(negedge clk); tdrWrite = 1'b0;
  endtask

  task automatic pulseRdrRead();
    @(negedge clk); rdrRead = 1'b1;
    @(negedge clk); rdrRead = 1'b0;
  endtask

  task automatic pulseRdrLoaded();
    @(negedge clk); rdrLoaded = 1'b1;
    @(negedge clk); rdrLoaded = 1'b0;
  endtask

  task automatic writeRst(input logic [3:0] v);
    @(negedge clk); rstCtlWrite = 1'b1; rstCtlVal = v;
    @(negedge clk); rstCtlWrite = 1'b0;
  endtask

  task automatic softReset();
    writeRst(4'h5); writeRst(4'hA);
  endtask

  task automatic runToStop();
    int guard = 0;
    maxIdx = 0;
    while (seqState == 2'd1 && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (int'(seqIndex) > maxIdx) maxIdx = int'(seqIndex);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not end, got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opWord = '0; loopCmp1 = '0; loopCmp2 = '0; rstCtlVal = '0;
    n2Reload = 0; rdrMatch = 0; shiftStop = 0; tdrTaken = 0; rdrLoaded = 0;
    tdrWrite = 0; rdrRead = 0; rstCtlWrite = 0;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();

    // R12 reset state
    check("R12 seqState", seqState, 0);
    check("R12 seqIndex", seqIndex, 0);
    check("R12 shifter", shifterState, 0);
    check("R12 csN", csN, 1);
    check("R12 flags", {tdrFull, rdrFull, tdrUnderrun, seqError}, 0);

    // R1/R2/R9 select, deselect, stop
    opWord = mk(8'h11, 8'h10, 8'h00);
    pulseTdr();
    check("R1 run starts", seqState, 1);
    check("R1 start index", seqIndex, 0);
    check("R6 tdrFull set", tdrFull, 1);
    step();
    check("R2 csN low", csN, 0);
    check("R2 shifter START", shifterState, 1);
    check("R1 index advance", seqIndex, 1);
    step();
    check("R2 csN high", csN, 1);
    check("R2 shifter DONE", shifterState, 5);
    step();
    check("R9 stop idle", seqState, 0);
    check("R9 stop index", seqIndex, 0);
    check("R9 stop shifter", shifterState, 0);

    // R2 invalid select argument
    opWord = mk(8'h13);
    pulseTdr(); step();
    check("R2 bad select halts", seqState, 2);
    check("R2 bad select index", seqIndex, 0);
    check("R2 bad select shifter", shifterState, 0);

    // R3 N1 while shifter idle
    softReset();
    opWord = mk(8'h31, 8'h00);
    pulseTdr(); step();
    check("R3 error set", seqError, 1);
    check("R3 halted", seqState, 2);
    check("R3 index held", seqIndex, 0);
    opWord = mk(8'h00);
    pulseTdr();
    check("R3 error cleared on start", seqError, 0);
    step();
    check("R3 resumed to stop", seqState, 0);

    // R3 N2 with no N1
    softReset();
    opWord = mk(8'h11, 8'h42);
    pulseTdr(); step(); step();
    check("R3 N2 error", seqError, 1);
    check("R3 N2 index", seqIndex, 1);

    // R4 combined frame
    softReset();
    opWord = mk(8'h11, 8'h32, 8'h42, 8'h10, 8'h00);
    pulseTdr(); step();
    check("R4 N1 request", shiftN1Req, 1);
    check("R4 combine", shiftCombine, 1);
    check("R4 arg", shiftArg, 2);
    step();
    check("R4 N2 request", shiftN2Req, 1);
    check("R4 shifter N1", shifterState, 2);
    step();
    check("R4 shifter N2", shifterState, 3);
    check("R4 index", seqIndex, 3);
    runToStop();

    // R5 combine with reload
    softReset();
    n2Reload = 1'b1;
    pulseTdr(); step(); step();
    check("R5 underrun", tdrUnderrun, 1);
    check("R5 halted", seqState, 2);
    check("R5 index advanced", seqIndex, 2);
    check("R5 shifter N2", shifterState, 3);
    pulseTdr();
    check("R6 underrun cleared", tdrUnderrun, 0);
    check("R6 resumes at index", seqIndex, 2);
    step();
    check("R5 N2 done", seqIndex, 3);
    n2Reload = 1'b0;
    runToStop();

    // R6 wait and resume
    softReset();
    opWord = mk(8'h11, 8'h31, 8'h10, 8'h00);
    pulseRdrRead();
    check("R6 rdrRead from idle ignored", seqState, 0);
    pulseRdrLoaded();
    check("R6 rdrFull set", rdrFull, 1);
    shiftStop = 1'b1;
    pulseTdr(); step(); step();
    check("R6 shifter WAIT", shifterState, 4);
    check("R6 halted", seqState, 2);
    check("R6 index held", seqIndex, 1);
    @(negedge clk); tdrTaken = 1'b1;
    @(negedge clk); tdrTaken = 1'b0;
    check("R6 tdrTaken clears", tdrFull, 0);
    shiftStop = 1'b0;
    pulseRdrRead();
    check("R6 rdrRead resumes", seqState, 1);
    check("R6 rdrFull cleared", rdrFull, 0);
    check("R6 resume index", seqIndex, 1);
    runToStop();
    check("R6 ends idle", seqState, 0);
    check("R6 deselected", csN, 1);

    // R7 branch mismatch
    softReset();
    opWord = mk(8'h63, 8'h00, 8'h00, 8'h20, 8'h00);
    rdrMatch = 1'b0;
    pulseTdr(); step();
    check("R7 no data waits", shifterState, 4);
    check("R7 no data halts", seqState, 2);
    pulseRdrLoaded();
    pulseTdr(); step();
    check("R7 mismatch jumps", seqIndex, 3);
    check("R7 rdrFull cleared", rdrFull, 0);
    step();
    check("R11 xfer advances", seqIndex, 4);
    runToStop();

    // R7 branch match
    softReset();
    pulseRdrLoaded();
    rdrMatch = 1'b1;
    pulseTdr(); step();
    check("R7 match advances", seqIndex, 1);
    check("R7 match clears rdrFull", rdrFull, 0);
    runToStop();

    // R9/R11 run off the end
    softReset();
    opWord = mk(8'h11, 8'h20, 8'h70, 8'h20, 8'h20, 8'h20, 8'h20, 8'h20);
    pulseTdr(); step(); step(); step();
    check("R11 unknown advances", seqIndex, 3);
    runToStop();
    check("R9 reached end", maxIdx, 8);
    check("R9 end idle", seqState, 0);
    check("R9 end index", seqIndex, 0);
    check("R9 end keeps select", csN, 0);

    // R8 loop counters: corners then random compare pairs
    softReset();
    opWord = mk(8'h11, 8'h31, 8'hE1, 8'hF1, 8'h10, 8'h00);
    for (int it = 0; it < 10; it++) begin
      int c1, c2;
      c1 = (it == 0) ? 0 : (it == 1) ? 15 : int'($urandom_range(15, 0));
      c2 = (it == 0) ? 0 : (it == 1) ? 15 : int'($urandom_range(15, 0));
      loopCmp1 = 4'(c1); loopCmp2 = 4'(c2);
      n1Count = 0;
      pulseTdr();
      runToStop();
      check("R8 loop shift count", n1Count, expLoopShifts(c1, c2));
      check("R9 loop end idle", seqState, 0);
      check("R8 loop deselect", csN, 1);
    end

    // R10 controller reset key
    softReset();
    opWord = mk(8'h11, 8'h13);
    pulseTdr(); step(); step();
    check("R10 setup halted", seqState, 2);
    writeRst(4'h5); writeRst(4'h3); writeRst(4'hA);
    check("R10 broken key ignored", csN, 0);
    check("R10 broken key state", seqState, 2);
    writeRst(4'h5); writeRst(4'hA);
    check("R10 reset csN", csN, 1);
    check("R10 reset state", seqState, 0);
    check("R10 reset shifter", shifterState, 0);
    check("R10 reset flags", {tdrFull, rdrFull, tdrUnderrun, seqError}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule